// File: doc/BRIEF.md
# Privilege and Stack-Select Mode Controller

This block keeps track of the operating state of a small processor core. It knows whether the core runs in thread mode or handler mode, whether thread code runs at the privileged or the user level, and which of two stack pointers is active: the main stack or the process stack. It holds a 2-bit control register and the two stack pointer registers. It also counts nested exceptions, so that handler mode lasts until the outermost handler returns.

Requests to move a special register to or from a general register arrive on a small request port. The block checks each request against the current level. Refused requests, and system-control-space accesses made at the user level, produce a one-cycle fault strobe and change nothing. The stack unit writes the active stack pointer through a separate port. The block does not decode instructions, move stack memory or choose exceptions.

Top module: `privModeCtl`

## Requirements
- R1: After reset the block is in thread mode at the privileged level, uses the main stack, and has faultStrobe and srRvalid low.
- R2: Register selector codes are 0 = control, 1 = main stack pointer, 2 = process stack pointer, 3 = reserved. In privileged thread mode, a write to the control register stores both bits. Bit 1 = 1 selects the process stack and bit 0 = 1 selects the user level. The new state shows on the outputs after the clock edge that takes the write.
- R3: In handler mode the effective value of both control bits is 0: userLevel and useProcStack are low, and a read of the control register returns 0.
- R4: excEnter raises handlerMode at the next edge and increments a nesting count that saturates at 2^NEST_W-1. At saturation a further entry is ignored. handlerMode stays high until the count returns to zero.
- R5: The return that empties the nesting count brings the block back to thread mode. The level then follows stored control bit 0 and the stack follows stored bit 1.
- R6: At the user level, a special-register read or write raises faultStrobe for one cycle after the request edge. It changes no register and gives no srRvalid.
- R7: scsAccess at the user level raises faultStrobe one cycle later. At the privileged level it raises no fault.
- R8: A control write made in handler mode updates bit 0 and leaves bit 1 unchanged.
- R9: A privileged read sets srRvalid, with srRdata holding the selected register, one cycle after the request edge. The reserved code reads as 0.
- R10: spWrEn writes spWdata into the active stack pointer. A privileged special-register write to the same stack pointer in the same cycle takes precedence.
- R11: When excEnter and excReturn arrive together, the entry is taken and the return is ignored. excReturn in thread mode has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| excEnter | input | 1 | Exception entry event |
| excReturn | input | 1 | Exception return event |
| srValid | input | 1 | Special-register request |
| srWrite | input | 1 | Request is a write (1) or read (0) |
| srSel | input | 2 | Register selector |
| srWdata | input | DATA_W | Write data for a special-register write |
| scsAccess | input | 1 | System-control-space access attempt |
| spWrEn | input | 1 | Write to the active stack pointer |
| spWdata | input | DATA_W | Data for the active stack pointer |
| srRdata | output | DATA_W | Read data |
| srRvalid | output | 1 | Read data valid |
| activeSp | output | DATA_W | Value of the active stack pointer |
| handlerMode | output | 1 | Handler mode |
| userLevel | output | 1 | User access level |
| useProcStack | output | 1 | Process stack selected |
| faultStrobe | output | 1 | Illegal access pulse |

## Verification
The mode, level, stack selection and activeSp outputs all come from registers that change at the edge which takes the event or write. The bench therefore samples them 5 ns after that edge. faultStrobe, srRvalid and srRdata are registered one stage after the request edge, so they are sampled at the same point, while the request inputs are still applied. The bench keeps its own model of the stored control bits and the nesting depth. It sweeps every pair made of a thread-mode control value and a handler-mode control value, and derives each expected output from that model.

// File: rtl/privmode_pkg.sv
package privmode_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_MSP  = 2'd1,
    SEL_PSP  = 2'd2,
    SEL_RSVD = 2'd3
  } srSel_e;

  localparam int NUM_SP = 2;

  typedef struct packed {
    logic   wrBit0;
    logic   wrBit1;
    logic   wrMsp;
    logic   mspFromSr;
    logic   wrPsp;
    logic   pspFromSr;
    logic   rdEn;
    srSel_e rdSel;
  } dpStrobe_t;

endpackage

// File: rtl/privmode_ctrl.sv
module privmode_ctrl
  import privmode_pkg::*;
#(
  parameter int NEST_W = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       excEnter,
  input  logic       excReturn,
  input  logic       srValid,
  input  logic       srWrite,
  input  logic [1:0] srSel,
  input  logic       scsAccess,
  input  logic       spWrEn,
  input  logic       ctrlBit0,
  input  logic       ctrlBit1,
  output dpStrobe_t  strobe,
  output logic       handlerMode,
  output logic       userLevel,
  output logic       useProcStack,
  output logic       faultStrobe
);

  localparam logic [NEST_W-1:0] NEST_MAX = {NEST_W{1'b1}};
  localparam logic [NEST_W-1:0] NEST_ONE = {{(NEST_W-1){1'b0}}, 1'b1};

  logic [NEST_W-1:0] nestCnt;
  logic              accOk;
  logic              srWrOk;
  srSel_e            selNow;

  assign handlerMode  = (nestCnt != '0);
  assign userLevel    = !handlerMode && ctrlBit0;
  assign useProcStack = !handlerMode && ctrlBit1;

  assign selNow = srSel_e'(srSel);
  assign accOk  = srValid && !userLevel;
  assign srWrOk = accOk && srWrite;

  always_comb begin
    strobe           = '0;
    strobe.wrBit0    = srWrOk && (selNow == SEL_CTRL);
    strobe.wrBit1    = srWrOk && (selNow == SEL_CTRL) && !handlerMode;
    strobe.mspFromSr = srWrOk && (selNow == SEL_MSP);
    strobe.pspFromSr = srWrOk && (selNow == SEL_PSP);
    strobe.wrMsp     = strobe.mspFromSr || (spWrEn && !useProcStack);
    strobe.wrPsp     = strobe.pspFromSr || (spWrEn && useProcStack);
    strobe.rdEn      = accOk && !srWrite;
    strobe.rdSel     = selNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nestCnt <= '0;
    end else if (excEnter) begin
      if (nestCnt != NEST_MAX) nestCnt <= nestCnt + NEST_ONE;
    end else if (excReturn && handlerMode) begin
      nestCnt <= nestCnt - NEST_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) faultStrobe <= 1'b0;
    else       faultStrobe <= userLevel && (srValid || scsAccess);
  end

endmodule

// File: rtl/privmode_dp.sv
module privmode_dp
  import privmode_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              handlerMode,
  input  logic              useProcStack,
  input  logic [DATA_W-1:0] srWdata,
  input  logic [DATA_W-1:0] spWdata,
  output logic              ctrlBit0,
  output logic              ctrlBit1,
  output logic [DATA_W-1:0] srRdata,
  output logic              srRvalid,
  output logic [DATA_W-1:0] activeSp
);

  logic [DATA_W-1:0] spReg [NUM_SP];
  logic [NUM_SP-1:0] spWr;
  logic [NUM_SP-1:0] spFromSr;
  logic [DATA_W-1:0] rdNext;

  assign spWr     = {strobe.wrPsp, strobe.wrMsp};
  assign spFromSr = {strobe.pspFromSr, strobe.mspFromSr};

  for (genvar g = 0; g < NUM_SP; g++) begin : g_sp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        spReg[g] <= '0;
      else if (spWr[g]) spReg[g] <= spFromSr[g] ? srWdata : spWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlBit0 <= 1'b0;
      ctrlBit1 <= 1'b0;
    end else begin
      if (strobe.wrBit0) ctrlBit0 <= srWdata[0];
      if (strobe.wrBit1) ctrlBit1 <= srWdata[1];
    end
  end

  always_comb begin
    rdNext = '0;
    unique case (strobe.rdSel)
      SEL_CTRL: begin
        rdNext[0] = !handlerMode && ctrlBit0;
        rdNext[1] = !handlerMode && ctrlBit1;
      end
      SEL_MSP:  rdNext = spReg[0];
      SEL_PSP:  rdNext = spReg[1];
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srRdata  <= '0;
      srRvalid <= 1'b0;
    end else begin
      srRvalid <= strobe.rdEn;
      srRdata  <= strobe.rdEn ? rdNext : '0;
    end
  end

  assign activeSp = useProcStack ? spReg[1] : spReg[0];

endmodule

// File: rtl/privModeCtl.sv
module privModeCtl
  import privmode_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NEST_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excEnter,
  input  logic              excReturn,
  input  logic              srValid,
  input  logic              srWrite,
  input  logic [1:0]        srSel,
  input  logic [DATA_W-1:0] srWdata,
  input  logic              scsAccess,
  input  logic              spWrEn,
  input  logic [DATA_W-1:0] spWdata,
  output logic [DATA_W-1:0] srRdata,
  output logic              srRvalid,
  output logic [DATA_W-1:0] activeSp,
  output logic              handlerMode,
  output logic              userLevel,
  output logic              useProcStack,
  output logic              faultStrobe
);

  dpStrobe_t strobe;
  logic      ctrlBit0;
  logic      ctrlBit1;

  privmode_ctrl #(.NEST_W(NEST_W)) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .excEnter     (excEnter),
    .excReturn    (excReturn),
    .srValid      (srValid),
    .srWrite      (srWrite),
    .srSel        (srSel),
    .scsAccess    (scsAccess),
    .spWrEn       (spWrEn),
    .ctrlBit0     (ctrlBit0),
    .ctrlBit1     (ctrlBit1),
    .strobe       (strobe),
    .handlerMode  (handlerMode),
    .userLevel    (userLevel),
    .useProcStack (useProcStack),
    .faultStrobe  (faultStrobe)
  );

  privmode_dp #(.DATA_W(DATA_W)) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .handlerMode  (handlerMode),
    .useProcStack (useProcStack),
    .srWdata      (srWdata),
    .spWdata      (spWdata),
    .ctrlBit0     (ctrlBit0),
    .ctrlBit1     (ctrlBit1),
    .srRdata      (srRdata),
    .srRvalid     (srRvalid),
    .activeSp     (activeSp)
  );

endmodule

// File: rtl/privModeCtl_checker.sv
module privModeCtl_checker (
  input logic clk,
  input logic rstN,
  input logic excEnter,
  input logic srValid,
  input logic srWrite,
  input logic handlerMode,
  input logic userLevel,
  input logic useProcStack,
  input logic faultStrobe,
  input logic srRvalid
);

  p_user_only_thread_r3: assert property (@(posedge clk) disable iff (!rstN)
    userLevel |-> !handlerMode);

  p_handler_main_stack_r3: assert property (@(posedge clk) disable iff (!rstN)
    handlerMode |-> !useProcStack);

  p_enter_handler_r4: assert property (@(posedge clk) disable iff (!rstN)
    excEnter |=> handlerMode);

  p_user_access_fault_r6: assert property (@(posedge clk) disable iff (!rstN)
    (srValid && userLevel) |=> faultStrobe);

  p_user_no_rvalid_r6: assert property (@(posedge clk) disable iff (!rstN)
    userLevel |=> !srRvalid);

  p_user_write_blocked_r6: assert property (@(posedge clk) disable iff (!rstN)
    (userLevel && srValid && !excEnter) |=> userLevel);

  p_priv_no_fault_r7: assert property (@(posedge clk) disable iff (!rstN)
    !userLevel |=> !faultStrobe);

  p_priv_read_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    (srValid && !srWrite && !userLevel) |=> srRvalid);

endmodule

bind privModeCtl privModeCtl_checker i_chk (.*);

// File: tb/test_privModeCtl.sv
module test_privModeCtl;

  localparam int DW = 32;
  localparam int NW = 3;
  localparam int NEST_MAX = (1 << NW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          excEnter = 0, excReturn = 0, srValid = 0, srWrite = 0;
  logic [1:0]    srSel = 0;
  logic [DW-1:0] srWdata = 0, spWdata = 0;
  logic          scsAccess = 0, spWrEn = 0;
  logic [DW-1:0] srRdata, activeSp;
  logic          srRvalid, handlerMode, userLevel, useProcStack, faultStrobe;

  int nChecks = 0;
  int nErr = 0;

  always #10 clk = ~clk;

  privModeCtl #(.DATA_W(DW), .NEST_W(NW)) i_privModeCtl (.*);

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic srWr(logic [1:0] sel, logic [DW-1:0] d);
    srValid = 1; srWrite = 1; srSel = sel; srWdata = d;
    step();
    srValid = 0; srWrite = 0;
  endtask

  task automatic srRd(logic [1:0] sel, output logic [DW-1:0] d, output logic v,
                      output logic f);
    srValid = 1; srWrite = 0; srSel = sel;
    step();
    d = srRdata; v = srRvalid; f = faultStrobe;
    srValid = 0;
  endtask

  task automatic enter();
    excEnter = 1; step(); excEnter = 0;
  endtask

  task automatic leave();
    excReturn = 1; step(); excReturn = 0;
  endtask

  logic [DW-1:0] rd;
  logic rv, rf;

  initial begin
    #25 rstN = 1'b1;
    step();
    // R1 reset state
    check("R1 handler", handlerMode, 0);
    check("R1 user", userLevel, 0);
    check("R1 stack", useProcStack, 0);
    check("R1 fault", faultStrobe, 0);
    check("R1 rvalid", srRvalid, 0);

    // Sweep thread value a and handler value b
    for (int a = 0; a < 4; a++) begin
      srWr(2'd0, DW'(a));
      check("R2 user", userLevel, DW'(a & 1));
      check("R2 stack", useProcStack, DW'((a >> 1) & 1));
      srRd(2'd0, rd, rv, rf);
      if ((a & 1) == 0) begin
        check("R9 rvalid", rv, 1);
        check("R9 ctrl read", rd, DW'(a));
      end else begin
        check("R6 fault", rf, 1);
        check("R6 no rvalid", rv, 0);
      end
      enter();
      check("R4 handler", handlerMode, 1);
      check("R3 user", userLevel, 0);
      check("R3 stack", useProcStack, 0);
      srRd(2'd0, rd, rv, rf);
      check("R3 ctrl read", rd, 0);
      leave();
      for (int b = 0; b < 4; b++) begin
        enter();
        srWr(2'd0, DW'(b));
        check("R3 stack in handler", useProcStack, 0);
        leave();
        check("R5 thread", handlerMode, 0);
        check("R8 user from bit0", userLevel, DW'(b & 1));
        check("R8 bit1 kept", useProcStack, DW'((a >> 1) & 1));
        enter();
        srWr(2'd0, 0);
        leave();
      end
      srWr(2'd0, 0);
      check("R2 cleared", useProcStack, 0);
    end

    // R6 user-level writes blocked
    srWr(2'd1, 32'h100);
    check("R6 setup msp", activeSp, 32'h100);
    srWr(2'd0, 1);
    check("R2 user on", userLevel, 1);
    srWr(2'd0, 0);
    check("R6 write fault", faultStrobe, 1);
    check("R6 still user", userLevel, 1);
    srWr(2'd1, 32'h55);
    check("R6 msp unchanged", activeSp, 32'h100);
    // R7 scs at user level
    scsAccess = 1; step(); scsAccess = 0;
    check("R7 user scs fault", faultStrobe, 1);
    step();
    check("R6 fault one cycle", faultStrobe, 0);
    enter(); srWr(2'd0, 0); leave();
    check("R5 back to priv", userLevel, 0);
    scsAccess = 1; step(); scsAccess = 0;
    check("R7 priv scs no fault", faultStrobe, 0);

    // R11 return in thread ignored, simultaneous events
    leave();
    check("R11 ret in thread", handlerMode, 0);
    excEnter = 1; excReturn = 1; step(); excEnter = 0; excReturn = 0;
    check("R11 enter wins", handlerMode, 1);
    leave();
    check("R11 back thread", handlerMode, 0);

    // R4 nesting and saturation
    for (int i = 0; i < NEST_MAX + 1; i++) enter();
    for (int i = 0; i < NEST_MAX - 1; i++) leave();
    check("R4 nested still handler", handlerMode, 1);
    leave();
    check("R4 outermost return", handlerMode, 0);

    // R10 active stack writes
    srWr(2'd0, 2);
    check("R2 process stack", useProcStack, 1);
    spWrEn = 1; spWdata = 32'hAAAA; step(); spWrEn = 0;
    check("R10 psp via sp port", activeSp, 32'hAAAA);
    srRd(2'd1, rd, rv, rf);
    check("R10 msp untouched", rd, 32'h100);
    spWrEn = 1; spWdata = 32'h9999;
    srWr(2'd2, 32'h1234);
    spWrEn = 0;
    check("R10 sr write wins", activeSp, 32'h1234);
    srRd(2'd2, rd, rv, rf);
    check("R9 psp read", rd, 32'h1234);
    srRd(2'd3, rd, rv, rf);
    check("R9 reserved read", rd, 0);
    check("R9 reserved rvalid", rv, 1);
    enter();
    check("R3 handler uses msp", activeSp, 32'h100);
    leave();
    check("R5 psp restored", activeSp, 32'h1234);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    nErr++;
    nChecks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule